// File: doc/BRIEF.md
# PPS-Aligned Seconds/Ticks Timekeeper

This block keeps wall-clock time as two fields: a whole-seconds count and a sub-second tick count. The tick field advances on every clock and, on reaching a programmable ticks-per-second limit, returns to zero while the seconds field steps by one. Both fields are presented on output pins continuously, so any consumer can read the current time.

Software changes the time through a simple write-only setting bus (strobe, address, data). It first writes the pending seconds value, then the pending ticks value; the ticks write arms a load. A commit-mode register decides when the armed load takes effect: at once, or at the next active edge of a pulse-per-second (PPS) signal. The PPS can be taken from either of two inputs, and the edge that counts (rising or falling) is programmable. It passes through a two-flop synchroniser before edge detection. When the load commits, both fields change in the same clock cycle.

The setting bus carries no back-pressure: a write is taken in the cycle its strobe is high, and the sender needs no ready signal. The time outputs are plain status pins, valid in every cycle.

Top module: `timekeeper_pps`

## Requirements
- R1: While reset is high, and in the first cycle after it, both time outputs read zero. Reset also clears the arm, sets commit mode to 0, sets the edge/source flags to 0, and sets ticks-per-second to the parameter DEF_TPS.
- R2: With no commit, ticks rises by one per clock. In the cycle after ticks equals tps-1 (or when tps is 0 or 1), ticks becomes 0 and seconds rises by one.
- R3: Setting registers sit at BASE_ADDR plus an offset: 0 pending seconds, 1 pending ticks, 2 flags, 3 commit mode, 4 ticks-per-second. A write to offset 0 only stores the pending seconds and leaves the time unchanged. A write to offset 1 arms the load.
- R4: When commit mode (offset 3, bit 0) is 1, an armed load commits at the next clock edge after the ticks write. Both outputs then show the pending values together.
- R5: When commit mode is 0, an armed load waits for the selected PPS edge. The new time is visible after the third rising clock edge that follows the PPS input transition (two synchroniser stages plus one edge-detect stage).
- R6: Flags bit 0 selects the active PPS edge: 0 is falling, 1 is rising. A transition of the other polarity commits nothing.
- R7: Flags bit 1 selects the PPS input: 0 selects pps_ext, 1 selects pps_sync. Activity on the unselected input has no effect.
- R8: A commit clears the arm. A later PPS edge with nothing armed leaves the time counting normally.
- R9: A commit takes priority over the tick rollover. If a load commits while ticks equals tps-1, the loaded values appear and seconds is not also incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_stb | input | 1 | Setting-bus write strobe |
| set_addr | input | ADDR_W | Setting-bus word address |
| set_data | input | DATA_W | Setting-bus write data |
| pps_ext | input | 1 | PPS from the external connector |
| pps_sync | input | 1 | PPS from the inter-unit sync link |
| time_secs | output | DATA_W | Current seconds |
| time_ticks | output | DATA_W | Current ticks within the second |

## Verification
The hardest case to reach from the ports is a commit that lands in the exact cycle where ticks sits at tps-1. That is where the load/rollover priority matters. The bench gets there in immediate mode with a small tps: it holds the strobe for two cycles, first writing ticks = tps-1 (which commits) and then a second ticks value. That second value commits in the cycle where the counter is at the rollover point. The PPS path is exercised with wrong-polarity edges and edges on the unselected input before the correct edge. The sampling point is counted through the synchroniser depth.

// File: rtl/tk_pkg.sv
package tk_pkg;
  typedef enum logic [2:0] {
    OFS_SECS  = 3'd0,
    OFS_TICKS = 3'd1,
    OFS_FLAGS = 3'd2,
    OFS_MODE  = 3'd3,
    OFS_TPS   = 3'd4
  } tk_ofs_e;

  typedef struct packed {
    logic src_sync;   // bit 1: 1 selects the sync-link input
    logic edge_rise;  // bit 0: 1 selects the rising edge
  } tk_flags_t;
endpackage

// File: rtl/tk_regs.sv
module tk_regs
  import tk_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter int unsigned BASE_ADDR = 32,
  parameter int unsigned DEF_TPS   = 100_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_stb,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic [DATA_W-1:0] set_data,
  input  logic              commit,
  output logic [DATA_W-1:0] pend_secs,
  output logic [DATA_W-1:0] pend_ticks,
  output tk_flags_t         flags,
  output logic              imm_mode,
  output logic [DATA_W-1:0] tps,
  output logic              armed
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  function automatic logic hit(input tk_ofs_e ofs);
    return set_stb && (set_addr == BASE + ADDR_W'(ofs));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_secs  <= '0;
      pend_ticks <= '0;
      flags      <= '0;
      imm_mode   <= 1'b0;
      tps        <= DATA_W'(DEF_TPS);
      armed      <= 1'b0;
    end else begin
      if (hit(OFS_SECS))  pend_secs  <= set_data;
      if (hit(OFS_TICKS)) pend_ticks <= set_data;
      if (hit(OFS_FLAGS)) flags      <= set_data[1:0];
      if (hit(OFS_MODE))  imm_mode   <= set_data[0];
      if (hit(OFS_TPS))   tps        <= set_data;
      if (hit(OFS_TICKS))  armed <= 1'b1;
      else if (commit)     armed <= 1'b0;
    end
  end
endmodule

// File: rtl/tk_pps.sv
module tk_pps
  import tk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pps_ext,
  input  logic      pps_sync,
  input  tk_flags_t flags,
  output logic      pps_ev
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic               pps_sel;
  logic [CHAIN_W-1:0] chain;
  logic               cur, prev;

  assign pps_sel = flags.src_sync ? pps_sync : pps_ext;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[CHAIN_W-2:0], pps_sel};
  end

  assign cur  = chain[SYNC_STAGES-1];
  assign prev = chain[SYNC_STAGES];

  always_comb begin
    if (flags.edge_rise) pps_ev = cur & ~prev;
    else                 pps_ev = ~cur & prev;
  end
endmodule

// File: rtl/tk_count.sv
module tk_count #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [DATA_W-1:0] pend_secs,
  input  logic [DATA_W-1:0] pend_ticks,
  input  logic [DATA_W-1:0] tps,
  output logic [DATA_W-1:0] secs,
  output logic [DATA_W-1:0] ticks
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic wrap;
  assign wrap = (tps <= ONE) || (ticks >= tps - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      secs  <= '0;
      ticks <= '0;
    end else if (commit) begin
      secs  <= pend_secs;
      ticks <= pend_ticks;
    end else if (wrap) begin
      secs  <= secs + ONE;
      ticks <= '0;
    end else begin
      ticks <= ticks + ONE;
    end
  end
endmodule

// File: rtl/timekeeper_pps.sv
module timekeeper_pps
  import tk_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 32,
  parameter int unsigned BASE_ADDR   = 32,
  parameter int unsigned DEF_TPS     = 100_000_000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_stb,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic [DATA_W-1:0] set_data,
  input  logic              pps_ext,
  input  logic              pps_sync,
  output logic [DATA_W-1:0] time_secs,
  output logic [DATA_W-1:0] time_ticks
);
  logic [DATA_W-1:0] pend_secs, pend_ticks, tps;
  tk_flags_t         flags;
  logic              imm_mode, armed, pps_ev, commit;

  assign commit = armed & (imm_mode | pps_ev);

  tk_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR), .DEF_TPS(DEF_TPS)
  ) u_regs (
    .clk(clk), .rst(rst), .set_stb(set_stb), .set_addr(set_addr),
    .set_data(set_data), .commit(commit), .pend_secs(pend_secs),
    .pend_ticks(pend_ticks), .flags(flags), .imm_mode(imm_mode),
    .tps(tps), .armed(armed)
  );

  tk_pps #(.SYNC_STAGES(SYNC_STAGES)) u_pps (
    .clk(clk), .rst(rst), .pps_ext(pps_ext), .pps_sync(pps_sync),
    .flags(flags), .pps_ev(pps_ev)
  );

  tk_count #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .commit(commit), .pend_secs(pend_secs),
    .pend_ticks(pend_ticks), .tps(tps), .secs(time_secs), .ticks(time_ticks)
  );
endmodule

// File: rtl/tk_checker.sv
module tk_checker #(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter int unsigned BASE_ADDR = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              set_stb,
  input logic [ADDR_W-1:0] set_addr,
  input logic [DATA_W-1:0] time_secs,
  input logic [DATA_W-1:0] time_ticks,
  input logic [DATA_W-1:0] pend_secs,
  input logic [DATA_W-1:0] pend_ticks,
  input logic [DATA_W-1:0] tps,
  input logic              imm_mode,
  input logic              armed,
  input logic              commit
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam logic [ADDR_W-1:0] TICKS_ADDR = ADDR_W'(BASE_ADDR + 1);

  logic ticks_wr;
  assign ticks_wr = set_stb && (set_addr == TICKS_ADDR);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (time_secs == '0 && time_ticks == '0)); // R1

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
    (!commit && tps > ONE && time_ticks < tps - ONE)
    |=> (time_ticks == $past(time_ticks) + ONE && $stable(time_secs))); // R2

  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!commit && tps > ONE && time_ticks >= tps - ONE)
    |=> (time_ticks == '0 && time_secs == $past(time_secs) + ONE)); // R2

  AST_ARM_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    ticks_wr |=> armed); // R3

  AST_IMM_DISARM: assert property (@(posedge clk) disable iff (rst)
    (armed && imm_mode && !ticks_wr) |=> !armed); // R4

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    commit |=> (time_secs == $past(pend_secs) && time_ticks == $past(pend_ticks))); // R9
endmodule

bind timekeeper_pps tk_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .set_stb(set_stb), .set_addr(set_addr),
  .time_secs(time_secs), .time_ticks(time_ticks), .pend_secs(pend_secs),
  .pend_ticks(pend_ticks), .tps(tps), .imm_mode(imm_mode), .armed(armed),
  .commit(commit)
);

// File: tb/timekeeper_pps_test.sv
`timescale 1ns/1ps
module timekeeper_pps_test;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int unsigned BASE = 32;
  localparam int O_SECS = 0, O_TICKS = 1, O_FLAGS = 2, O_MODE = 3, O_TPS = 4;

  typedef struct packed {
    logic [31:0] tps, s, t, n, es, et;
  } vec_t;

  // immediate loads followed by n cycles of free running (R2, R4)
  localparam vec_t VECS [5] = '{
    '{32'd10, 32'd5,   32'd3, 32'd4, 32'd5,   32'd7},
    '{32'd10, 32'd5,   32'd8, 32'd3, 32'd6,   32'd1},
    '{32'd4,  32'd0,   32'd0, 32'd9, 32'd2,   32'd1},
    '{32'd7,  32'd100, 32'd6, 32'd1, 32'd101, 32'd0},
    '{32'd1,  32'd9,   32'd0, 32'd5, 32'd14,  32'd0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              set_stb = 1'b0;
  logic [ADDR_W-1:0] set_addr = '0;
  logic [DATA_W-1:0] set_data = '0;
  logic              pps_ext = 1'b0;
  logic              pps_sync = 1'b0;
  logic [DATA_W-1:0] time_secs, time_ticks;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  timekeeper_pps #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE)) uut (
    .clk(clk), .rst(rst), .set_stb(set_stb), .set_addr(set_addr),
    .set_data(set_data), .pps_ext(pps_ext), .pps_sync(pps_sync),
    .time_secs(time_secs), .time_ticks(time_ticks)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ofs, input logic [31:0] d);
    @(negedge clk);
    set_stb  = 1'b1;
    set_addr = ADDR_W'(BASE + ofs);
    set_data = d;
    @(negedge clk);
    set_stb  = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 secs in reset", time_secs, 0);
    check("R1 ticks in reset", time_ticks, 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check("R2 free run ticks", time_ticks, 6);
    check("R2 free run secs", time_secs, 0);

    // R3: seconds write alone does nothing; ticks write arms
    wr(O_MODE, 1);
    wr(O_SECS, 77);
    repeat (4) @(negedge clk);
    check("R3 secs write alone ignored", time_secs, 0);
    wr(O_TICKS, 3);
    @(negedge clk);
    check("R4 immediate secs", time_secs, 77);
    check("R4 immediate ticks", time_ticks, 3);

    // table walk
    foreach (VECS[i]) begin
      wr(O_TPS, VECS[i].tps);
      wr(O_SECS, VECS[i].s);
      wr(O_TICKS, VECS[i].t);
      repeat (VECS[i].n + 1) @(negedge clk);
      check($sformatf("R2 vec%0d secs", i), time_secs, VECS[i].es);
      check($sformatf("R2 vec%0d ticks", i), time_ticks, VECS[i].et);
    end

    // PPS, falling edge, external input
    wr(O_MODE, 0);
    wr(O_TPS, 1000);
    wr(O_FLAGS, 0);
    wr(O_SECS, 500);
    wr(O_TICKS, 20);
    repeat (5) @(negedge clk);
    check("R5 armed waits for PPS", time_secs == 500, 0);
    pps_ext = 1'b1;
    repeat (6) @(negedge clk);
    check("R6 rising ignored in falling mode", time_secs == 500, 0);
    pps_ext = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 PPS load secs", time_secs, 500);
    check("R5 PPS load ticks", time_ticks, 20);
    pps_ext = 1'b1;
    repeat (4) @(negedge clk);
    pps_ext = 1'b0;
    repeat (6) @(negedge clk);
    check("R8 unarmed PPS keeps counting", time_ticks, 30);
    check("R8 unarmed PPS secs", time_secs, 500);

    // PPS, rising edge, sync input
    wr(O_FLAGS, 3);
    wr(O_SECS, 900);
    wr(O_TICKS, 5);
    pps_ext = 1'b1;
    repeat (5) @(negedge clk);
    pps_ext = 1'b0;
    repeat (5) @(negedge clk);
    check("R7 unselected input ignored", time_secs, 500);
    pps_sync = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 sync input rising secs", time_secs, 900);
    check("R6 rising edge ticks", time_ticks, 5);

    // R9: commit coinciding with rollover point
    wr(O_MODE, 1);
    wr(O_TPS, 10);
    wr(O_SECS, 40);
    @(negedge clk);
    set_stb = 1'b1; set_addr = ADDR_W'(BASE + O_TICKS); set_data = 9;
    @(negedge clk);
    set_data = 4;
    @(negedge clk);
    set_stb = 1'b0;
    check("R9 first load at tps-1", time_ticks, 9);
    @(negedge clk);
    check("R9 load beats rollover ticks", time_ticks, 4);
    check("R9 load beats rollover secs", time_secs, 40);
    @(negedge clk);
    check("R9 counting resumes", time_ticks, 5);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule